// File: doc/BRIEF.md
# Limp-Home Safe-State Controller

This block decides what the output channels of a multi-channel high-side switch do when the system can no longer be trusted to command them. There are two ways into the fail-safe mode. The first is a dedicated safe-mode input pin, driven high by the system. The second is a timeout pulse from the serial-port watchdog, which counts only while the watchdog enable is set. While the mode is active, every channel takes its output from its own 2-bit safe-state code. Host register writes are refused during the mode. The controller also changes how latch-off and cooldown fault holds apply to each channel.

The mode remembers why it was entered, and the way out depends on that cause. After a pin entry, the status flag is set. Leaving then needs the pin to be low and the host to write the flag clear. After a watchdog entry, the status flag stays low. The mode ends by itself on the next valid serial transaction. If the pin rises during a watchdog entry, the pin rules take over. A sticky watchdog error flag records every enabled timeout.

The pin path runs even while the logic supply is flagged as undervoltage. During that undervoltage, all host-side strobes are ignored: the valid-transaction pulse, writes, the flag clear and the fault read.

Top module: `limp_home_ctrl`

## Requirements
- R1: After reset the mode is inactive, `lh_stat` and `wd_err` are 0, and each `ch_en` bit equals its `ch_on` bit when no fault hold is present.
- R2: A high `lh_pin` at a clock edge activates the mode and sets `lh_stat` from the next cycle.
- R3: A `wd_timeout` pulse with `wd_en`=1 activates the mode and leaves `lh_stat` at 0. With `wd_en`=0 the pulse has no effect.
- R4: In the mode, channel c's code `lh_code[2c+1:2c]` selects its output: 2'b00 gives `di_pin`, 2'b01 gives the `ch_on[c]` value sampled at the entry edge, 2'b10 gives OFF, and 2'b11 gives ON.
- R5: A pin-caused mode ends only at an edge where `lh_pin` is low and `stat_clr` is high. A clear while the pin is high, or a valid serial transaction alone, does not end it. Register contents such as `ch_on` and the codes are untouched.
- R6: A watchdog-caused mode ends at the edge of the first `spi_valid` pulse.
- R7: If `lh_pin` rises while a watchdog-caused mode is active, `lh_stat` becomes 1 and the R5 exit rule applies.
- R8: `wd_err` is set by an enabled timeout. A `fault_rd` pulse clears it only when no watchdog-caused mode is active and no timeout arrives in the same cycle.
- R9: `wr_en` follows `host_wr` only when the mode is inactive. During the mode it is 0.
- R10: Outside the mode, an `ocp_flt` or `tsd_flt` pulse on a channel with `latch_en` set holds that channel off until `ch_on` goes low. Entering the mode releases such a hold. Inside the mode these faults never hold a channel off.
- R11: An `i2t_flt` pulse on a channel whose cooldown code `cldn_code[2c+1:2c]` is 2'b00 holds the channel off, in or out of the mode, until `ch_on` is low outside the mode. Other cooldown codes create no hold.
- R12: `chg_run[c]` is `chg_active[c]` gated by the channel's current enable, so charging continues for an ON target and stops at once for an OFF target.
- R13: While `logic_uv` is 1, pin entry still works, but `spi_valid`, `host_wr`, `stat_clr` and `fault_rd` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lh_pin | input | 1 | Safe-mode request pin |
| logic_uv | input | 1 | Logic supply below undervoltage threshold |
| wd_en | input | 1 | Watchdog enable bit |
| wd_timeout | input | 1 | Watchdog timeout pulse |
| spi_valid | input | 1 | Valid serial transaction pulse |
| host_wr | input | 1 | Host register write request |
| stat_clr | input | 1 | Host write clearing the status flag |
| fault_rd | input | 1 | Host read of the fault register |
| di_pin | input | 1 | Direct input pin level |
| ch_on | input | N_CH | Per-channel ON bits |
| lh_code | input | 2*N_CH | Per-channel safe-state codes |
| latch_en | input | N_CH | Per-channel latch-off enable |
| ocp_flt | input | N_CH | Overcurrent fault pulses |
| tsd_flt | input | N_CH | Thermal shutdown fault pulses |
| i2t_flt | input | N_CH | Energy fault pulses |
| cldn_code | input | 2*N_CH | Per-channel cooldown codes |
| chg_active | input | N_CH | Channel is in inrush or capacitor charging |
| ch_en | output | N_CH | Channel output enables |
| chg_run | output | N_CH | Charging allowed to continue |
| lh_active | output | 1 | Safe mode active |
| lh_stat | output | 1 | Pin-caused safe mode status flag |
| wd_err | output | 1 | Sticky watchdog error flag |
| wr_en | output | 1 | Host write accepted |

## Verification
On every cycle, the assertions check three things. A rising status flag always follows a high pin. A watchdog-caused mode always ends on a valid transaction. No write is accepted during the mode. They also check that an energy hold keeps a channel off, and that entering the mode releases any latch-off hold. The scenarios cover the rest. Each code value must select the right output, and the value captured at entry must persist after `ch_on` changes. The order of the pin-low and flag-clear exit conditions matters, as does escalation from a watchdog cause to a pin cause. The scenarios also show that a hold created before entry survives the mode, and that host strobes are ignored during undervoltage.

// File: rtl/lh_pkg.sv
// Package: shared types for the limp-home controller.
// Assumes: one safe mode at a time; the cause is the only extra state.
package lh_pkg;
    localparam int LH_CODE_W = 2;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_LH_WD  = 2'd1,
        MODE_LH_PIN = 2'd2
    } lh_mode_e;

    typedef enum logic [1:0] {
        SEL_DI   = 2'b00,
        SEL_HOLD = 2'b01,
        SEL_OFF  = 2'b10,
        SEL_ON   = 2'b11
    } lh_sel_e;

    localparam logic [1:0] CLDN_INDEF = 2'b00;
endpackage

// File: rtl/lh_mode_ctrl.sv
// Module: lh_mode_ctrl
// Tracks the safe-mode state and its cause, the sticky watchdog error and
// the write gate. Assumes all inputs are synchronous to clk. Host-side
// strobes are masked while the logic supply is in undervoltage.
module lh_mode_ctrl
    import lh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lh_pin,
    input  logic logic_uv,
    input  logic wd_en,
    input  logic wd_timeout,
    input  logic spi_valid,
    input  logic host_wr,
    input  logic stat_clr,
    input  logic fault_rd,
    output logic lh_active,
    output logic lh_enter,
    output logic lh_stat,
    output logic wd_err,
    output logic wr_en
);
    lh_mode_e mode_q, mode_d;
    logic     wd_hit;
    logic     spi_ok, clr_ok, rd_ok;
    logic     wd_err_q;

    assign wd_hit = wd_en & wd_timeout;
    assign spi_ok = spi_valid & ~logic_uv;
    assign clr_ok = stat_clr & ~logic_uv;
    assign rd_ok  = fault_rd & ~logic_uv;

    // Next mode: the pin outranks the watchdog; each cause has its own exit.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_NORMAL: begin
                if (lh_pin)      mode_d = MODE_LH_PIN;
                else if (wd_hit) mode_d = MODE_LH_WD;
            end
            MODE_LH_WD: begin
                if (lh_pin)      mode_d = MODE_LH_PIN;
                else if (spi_ok) mode_d = MODE_NORMAL;
            end
            MODE_LH_PIN: begin
                if (!lh_pin && clr_ok) mode_d = MODE_NORMAL;
            end
            default: mode_d = MODE_NORMAL;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_NORMAL;
        else        mode_q <= mode_d;
    end

    // Sticky watchdog error: set on timeout, cleared by read once the cause is gone.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  wd_err_q <= 1'b0;
        else if (wd_hit)                             wd_err_q <= 1'b1;
        else if (rd_ok && mode_q != MODE_LH_WD)      wd_err_q <= 1'b0;
    end

    assign lh_active = (mode_q != MODE_NORMAL);
    assign lh_enter  = (mode_q == MODE_NORMAL) && (mode_d != MODE_NORMAL);
    assign lh_stat   = (mode_q == MODE_LH_PIN);
    assign wd_err    = wd_err_q;
    assign wr_en     = host_wr & ~logic_uv & ~lh_active;

    // R2: the status flag rises only after the pin was high.
    a_r2_stat_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lh_stat) |-> $past(lh_pin));
    // R6: a watchdog-caused mode ends on a valid transaction when the pin is low.
    a_r6_wd_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (lh_active && !lh_stat && !lh_pin && spi_valid && !logic_uv) |=> !lh_active);
    // R8: an enabled timeout always leaves the error flag set.
    a_r8_wd_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && wd_timeout) |=> wd_err);
    // R9: no write is accepted during the mode.
    a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        lh_active |-> !wr_en);
endmodule

// File: rtl/lh_chan.sv
// Module: lh_chan
// One channel: selects the safe-state target, keeps the latch-off and
// indefinite-cooldown holds, and gates the enable and charging outputs.
// Assumes lh_enter is high in the cycle before lh_active first rises.
module lh_chan
    import lh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lh_active,
    input  logic                 lh_enter,
    input  logic                 di_pin,
    input  logic                 ch_on,
    input  logic [LH_CODE_W-1:0] code,
    input  logic                 latch_en,
    input  logic                 ocp_flt,
    input  logic                 tsd_flt,
    input  logic                 i2t_flt,
    input  logic [1:0]           cldn,
    input  logic                 chg_active,
    output logic                 en,
    output logic                 chg_run
);
    logic held_q, lat_q, i2t_q, tgt;
    logic i2t_set;

    assign i2t_set = i2t_flt && (cldn == CLDN_INDEF);

    // Capture the ON bit up to the entry edge; hold it during the mode.
    always_ff @(posedge clk) begin
        if (!rst_n)          held_q <= 1'b0;
        else if (!lh_active) held_q <= ch_on;
    end

    // Latch-off hold: released on entry, never set in the mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lat_q <= 1'b0;
        else if (lh_enter || lh_active)     lat_q <= 1'b0;
        else if ((ocp_flt || tsd_flt) && latch_en) lat_q <= 1'b1;
        else if (!ch_on)                    lat_q <= 1'b0;
    end

    // Indefinite cooldown hold: survives the mode, released by turning the channel off.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  i2t_q <= 1'b0;
        else if (i2t_set)                            i2t_q <= 1'b1;
        else if (!lh_active && !lh_enter && !ch_on)  i2t_q <= 1'b0;
    end

    // Target selection from the safe-state code.
    always_comb begin
        if (!lh_active) tgt = ch_on;
        else begin
            unique case (lh_sel_e'(code))
                SEL_DI:   tgt = di_pin;
                SEL_HOLD: tgt = held_q;
                SEL_OFF:  tgt = 1'b0;
                SEL_ON:   tgt = 1'b1;
                default:  tgt = 1'b0;
            endcase
        end
    end

    assign en      = tgt & ~lat_q & ~i2t_q;
    assign chg_run = chg_active & en;

    // R10: entering the mode always releases a latch-off hold.
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lh_active) |-> !lat_q);
    // R11: an indefinite cooldown hold keeps the channel off.
    a_r11_i2t_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i2t_set) |-> !en);
endmodule

// File: rtl/limp_home_ctrl.sv
// Module: limp_home_ctrl (top)
// Safe-state controller for N_CH high-side channels. It joins one mode
// controller to one channel slice per output. Assumes the buses are packed
// with channel c at bits [2c+1:2c] for the 2-bit codes.
module limp_home_ctrl
    import lh_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lh_pin,
    input  logic                      logic_uv,
    input  logic                      wd_en,
    input  logic                      wd_timeout,
    input  logic                      spi_valid,
    input  logic                      host_wr,
    input  logic                      stat_clr,
    input  logic                      fault_rd,
    input  logic                      di_pin,
    input  logic [N_CH-1:0]           ch_on,
    input  logic [N_CH*LH_CODE_W-1:0] lh_code,
    input  logic [N_CH-1:0]           latch_en,
    input  logic [N_CH-1:0]           ocp_flt,
    input  logic [N_CH-1:0]           tsd_flt,
    input  logic [N_CH-1:0]           i2t_flt,
    input  logic [N_CH*2-1:0]         cldn_code,
    input  logic [N_CH-1:0]           chg_active,
    output logic [N_CH-1:0]           ch_en,
    output logic [N_CH-1:0]           chg_run,
    output logic                      lh_active,
    output logic                      lh_stat,
    output logic                      wd_err,
    output logic                      wr_en
);
    logic lh_enter;

    lh_mode_ctrl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .lh_pin     (lh_pin),
        .logic_uv   (logic_uv),
        .wd_en      (wd_en),
        .wd_timeout (wd_timeout),
        .spi_valid  (spi_valid),
        .host_wr    (host_wr),
        .stat_clr   (stat_clr),
        .fault_rd   (fault_rd),
        .lh_active  (lh_active),
        .lh_enter   (lh_enter),
        .lh_stat    (lh_stat),
        .wd_err     (wd_err),
        .wr_en      (wr_en)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        lh_chan u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .lh_active  (lh_active),
            .lh_enter   (lh_enter),
            .di_pin     (di_pin),
            .ch_on      (ch_on[c]),
            .code       (lh_code[c*LH_CODE_W +: LH_CODE_W]),
            .latch_en   (latch_en[c]),
            .ocp_flt    (ocp_flt[c]),
            .tsd_flt    (tsd_flt[c]),
            .i2t_flt    (i2t_flt[c]),
            .cldn       (cldn_code[c*2 +: 2]),
            .chg_active (chg_active[c]),
            .en         (ch_en[c]),
            .chg_run    (chg_run[c])
        );
    end
endmodule

// File: tb/limp_home_ctrl_test.sv
module limp_home_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lh_pin = 0, logic_uv = 0, wd_en = 0, wd_timeout = 0, spi_valid = 0;
    logic host_wr = 0, stat_clr = 0, fault_rd = 0, di_pin = 0;
    logic [1:0] ch_on = 0, latch_en = 0, ocp_flt = 0, tsd_flt = 0, i2t_flt = 0, chg_active = 0;
    logic [3:0] lh_code = 0, cldn_code = 4'b0101;
    logic [1:0] ch_en, chg_run;
    logic lh_active, lh_stat, wd_err, wr_en;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    limp_home_ctrl #(.N_CH(2)) uut (.*);

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_tick(ref logic s);
        s = 1'b1; tick(); s = 1'b0;
    endtask

    task automatic pin_exit();
        lh_pin = 0; tick();
        stat_clr = 1; tick(); stat_clr = 0;
    endtask

    task automatic t_reset();
        ch_on = 2'b01; #1;
        chk("R1 active", {7'd0, lh_active}, 8'd0);
        chk("R1 stat", {7'd0, lh_stat}, 8'd0);
        chk("R1 wd_err", {7'd0, wd_err}, 8'd0);
        chk("R1 en", {6'd0, ch_en}, 8'd1);
    endtask

    task automatic t_pin_codes();
        lh_code = 4'b0001; di_pin = 1; lh_pin = 1; tick();
        chk("R2 active", {7'd0, lh_active}, 8'd1);
        chk("R2 stat", {7'd0, lh_stat}, 8'd1);
        chk("R4 hold+di", {6'd0, ch_en}, 8'd3);
        ch_on = 2'b00; di_pin = 0; #1;
        chk("R4 hold kept, di low", {6'd0, ch_en}, 8'd1);
        lh_code = 4'b1110; #1;
        chk("R4 off/on", {6'd0, ch_en}, 8'd2);
    endtask

    task automatic t_pin_exit();
        host_wr = 1; #1;
        chk("R9 blocked", {7'd0, wr_en}, 8'd0);
        host_wr = 0;
        stat_clr = 1; tick(); stat_clr = 0;
        chk("R5 clr with pin high", {7'd0, lh_active}, 8'd1);
        pulse_tick(spi_valid);
        chk("R5 spi ignored", {7'd0, lh_active}, 8'd1);
        lh_pin = 0; tick();
        chk("R5 pin low only", {7'd0, lh_active}, 8'd1);
        stat_clr = 1; tick(); stat_clr = 0;
        chk("R5 exit", {6'd0, lh_active, lh_stat}, 8'd0);
        chk("R5 regs kept", {4'd0, lh_code}, 8'hE);
        host_wr = 1; #1;
        chk("R9 accepted", {7'd0, wr_en}, 8'd1);
        host_wr = 0;
    endtask

    task automatic t_wd();
        wd_en = 0; pulse_tick(wd_timeout);
        chk("R3 disabled", {6'd0, lh_active, wd_err}, 8'd0);
        wd_en = 1; lh_code = 4'b1111; ch_on = 0; pulse_tick(wd_timeout);
        chk("R3 wd entry", {5'd0, lh_active, lh_stat, wd_err}, 8'b101);
        chk("R4 forced on", {6'd0, ch_en}, 8'd3);
        pulse_tick(fault_rd);
        chk("R8 read while present", {7'd0, wd_err}, 8'd1);
        pulse_tick(spi_valid);
        chk("R6 exit", {7'd0, lh_active}, 8'd0);
        pulse_tick(fault_rd);
        chk("R8 cleared", {7'd0, wd_err}, 8'd0);
    endtask

    task automatic t_escalate();
        pulse_tick(wd_timeout);
        lh_pin = 1; tick();
        chk("R7 stat set", {6'd0, lh_active, lh_stat}, 8'd3);
        lh_pin = 0; pulse_tick(spi_valid);
        chk("R7 spi no exit", {7'd0, lh_active}, 8'd1);
        stat_clr = 1; tick(); stat_clr = 0;
        chk("R7 clr exit", {7'd0, lh_active}, 8'd0);
        pulse_tick(fault_rd);
    endtask

    task automatic t_faults();
        ch_on = 2'b11; latch_en = 2'b11; lh_code = 4'b1111; tick();
        ocp_flt = 2'b01; tick(); ocp_flt = 0;
        chk("R10 latched", {6'd0, ch_en}, 8'd2);
        lh_pin = 1; tick();
        chk("R10 released on entry", {6'd0, ch_en}, 8'd3);
        ocp_flt = 2'b01; tsd_flt = 2'b10; tick(); ocp_flt = 0; tsd_flt = 0;
        chk("R10 no latch in mode", {6'd0, ch_en}, 8'd3);
        pin_exit();
        chk("R10 after exit", {6'd0, ch_en}, 8'd3);
        latch_en = 0; tsd_flt = 2'b01; tick(); tsd_flt = 0;
        chk("R10 latch disabled", {6'd0, ch_en}, 8'd3);
    endtask

    task automatic t_i2t();
        cldn_code = 4'b0100; i2t_flt = 2'b11; tick(); i2t_flt = 0;
        chk("R11 indefinite only", {6'd0, ch_en}, 8'd2);
        lh_pin = 1; tick();
        chk("R11 kept in mode", {6'd0, ch_en}, 8'd2);
        cldn_code = 4'b0000; i2t_flt = 2'b10; tick(); i2t_flt = 0;
        chk("R11 set in mode", {6'd0, ch_en}, 8'd0);
        pin_exit();
        chk("R11 kept after exit", {6'd0, ch_en}, 8'd0);
        ch_on = 0; tick(); ch_on = 2'b11; #1;
        chk("R11 released", {6'd0, ch_en}, 8'd3);
        cldn_code = 4'b0101;
    endtask

    task automatic t_charge();
        chg_active = 2'b11; #1;
        chk("R12 normal", {6'd0, chg_run}, 8'd3);
        lh_code = 4'b1110; lh_pin = 1; tick();
        chk("R12 mode", {6'd0, chg_run}, 8'd2);
        pin_exit(); chg_active = 0;
    endtask

    task automatic t_uv();
        logic_uv = 1; lh_pin = 1; tick();
        chk("R13 pin entry", {6'd0, lh_active, lh_stat}, 8'd3);
        lh_pin = 0; stat_clr = 1; tick(); stat_clr = 0;
        chk("R13 clr ignored", {7'd0, lh_active}, 8'd1);
        logic_uv = 0; stat_clr = 1; tick(); stat_clr = 0;
        chk("R13 exit", {7'd0, lh_active}, 8'd0);
        logic_uv = 1; pulse_tick(wd_timeout);
        pulse_tick(spi_valid);
        chk("R13 spi ignored", {7'd0, lh_active}, 8'd1);
        logic_uv = 0; pulse_tick(spi_valid);
        chk("R13 spi exit", {7'd0, lh_active}, 8'd0);
        logic_uv = 1; pulse_tick(fault_rd);
        chk("R13 read ignored", {7'd0, wd_err}, 8'd1);
        host_wr = 1; #1;
        chk("R13 write ignored", {7'd0, wr_en}, 8'd0);
        host_wr = 0; logic_uv = 0;
    endtask

    initial begin
        fork
            begin
                tick(); tick(); tick();
                rst_n = 1; tick();
                t_reset();
                t_pin_codes();
                t_pin_exit();
                t_wd();
                t_escalate();
                t_faults();
                t_i2t();
                t_charge();
                t_uv();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule